// File: doc/BRIEF.md
# Break-Before-Make Channel Select Sequencer

This block drives the switch enables of an analog multiplexer from a small committed control word. The word carries an enable bit and a channel code. It is taken in on a one-cycle update strobe, which the surrounding serial interface raises when its bus STOP commits new control bits, and not when the command byte arrives. Each update starts a fixed sequence. Every switch opens at once. The block then waits a break interval counted in system clocks, and only then closes the switch or switches that the new word selects.

A variant input picks how the code is read. In single-ended mode, each of the eight enables belongs to one channel. In differential mode, the enables form four pairs, and the selected pair closes its positive and negative switch together. A busy flag is high for the whole all-off interval. An update that arrives during a running interval restarts it with the newest word, so no switch can ever close sooner than one full break interval after the last update.

Top module: `bbm_chsel_seq`

## Requirements
- R1: While reset is low at a clock edge, all switch enables and busy are 0 after that edge, and the latched control word is cleared with its enable bit at 0.
- R2: When upd_i is 1 at a clock edge, all switch enables are 0 and busy_o is 1 after that edge, whatever the previous state.
- R3: After an update edge, the enables stay all 0 and busy_o stays 1 for exactly BREAK_CYCLES clock cycles. At the edge BREAK_CYCLES cycles after the update, the new enables appear and busy_o falls.
- R4: The control word is ctrl_i[3] = enable and ctrl_i[2:0] = channel code. When the captured enable bit is 0, every switch enable stays 0 after the interval, whatever the code.
- R5: In single-ended mode (diff_i = 0) with the enable bit at 1, exactly sw_en_o[code] is set after the interval.
- R6: In differential mode (diff_i = 1) with the enable bit at 1 and code bit 2 at 0, channel k = code[1:0] sets sw_en_o[2k] (positive) and sw_en_o[2k+1] (negative), and no other bit.
- R7: In differential mode, a code with bit 2 at 1 leaves every switch off.
- R8: An update during a running interval restarts it: the enables stay 0 for BREAK_CYCLES cycles counted from the last update, and they then follow the last word.
- R9: ctrl_i and diff_i are sampled only in the cycle with upd_i at 1. At any other time they have no effect on sw_en_o or busy_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | One-cycle strobe that commits a new control word |
| ctrl_i | input | 4 | Control word: bit 3 enable, bits 2:0 channel code |
| diff_i | input | 1 | Variant: 0 single-ended, 1 differential pairs |
| sw_en_o | output | 8 | Switch enables; in differential mode bits 2k/2k+1 form pair k |
| busy_o | output | 1 | High during the all-off break interval |

## Verification
The hardest case to bring about from the ports is an update that lands in the middle of a running break. A naive design would keep the first deadline there and close a switch early. The stimulus sends a second update a few cycles into the interval and then checks every cycle until the full interval from the second strobe has passed. In a separate test, the bench changes ctrl_i and diff_i in the cycles right after an update and while the block is idle, to show that only the strobed value counts.

// File: rtl/bbm_seq_pkg.sv
// Package: shared types for the break-before-make channel sequencer.
// Assumes the control word is an enable bit above a binary channel code.
package bbm_seq_pkg;

    // Sequencer phase: idle (enables valid) or in the all-off break.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_BREAK = 1'b1
    } seq_phase_t;

    // Returns the width of a down-counter able to hold (n - 1), at least 1.
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = (n > 1) ? $clog2(n) : 1;
        return w;
    endfunction

endpackage

// File: rtl/bbm_ctrl_capture.sv
// Control capture: holds the control word and the variant bit seen on the
// cycle of an update strobe. Assumes the strobe is one clock wide; a longer
// strobe simply recaptures each cycle. Clears to enable = 0 on reset.
module bbm_ctrl_capture #(
    parameter int unsigned CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              diff_i,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              diff_q
);

    // Register the word and variant only when a load is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            diff_q <= 1'b0;
        end else if (load_i) begin
            ctrl_q <= ctrl_i;
            diff_q <= diff_i;
        end
    end

endmodule

// File: rtl/bbm_break_timer.sv
// Break timer: after a start pulse, stays running for exactly BREAK_CYCLES
// clock cycles and raises a one-cycle done in the last of them. A new start
// while running reloads the full interval. Assumes BREAK_CYCLES >= 1.
module bbm_break_timer
    import bbm_seq_pkg::*;
#(
    parameter int unsigned BREAK_CYCLES = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic running_o,
    output logic done_o
);

    localparam int unsigned CNT_W = cnt_width(BREAK_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BREAK_CYCLES - 1);

    seq_phase_t       phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Done fires in the final running cycle unless a restart overrides it.
    always_comb begin
        done_o = (phase_q == SEQ_BREAK) && (cnt_q == '0) && !start_i;
    end

    assign running_o = (phase_q == SEQ_BREAK);

    // Load on start, count down while breaking, return to idle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (start_i) begin
            phase_q <= SEQ_BREAK;
            cnt_q   <= LOAD_VAL;
        end else if (phase_q == SEQ_BREAK) begin
            if (cnt_q == '0) begin
                phase_q <= SEQ_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/bbm_chan_decode.sv
// Channel decoder: turns an enable bit and a channel code into switch
// enables. Single-ended mode sets one bit per channel; differential mode
// sets the adjacent pair 2k/2k+1 for channel k and treats codes with the
// top code bit set as all off. Purely combinational; assumes N_SW is a
// power of two and at least 4.
module bbm_chan_decode #(
    parameter int unsigned N_SW = 8
) (
    input  logic                     en_i,
    input  logic [$clog2(N_SW)-1:0]  code_i,
    input  logic                     diff_i,
    output logic [N_SW-1:0]          sw_en_o
);

    localparam int unsigned SEL_W  = $clog2(N_SW);
    localparam int unsigned PAIR_W = SEL_W - 1;

    logic pair_range_ok;

    // A differential code is usable only with its top bit clear.
    assign pair_range_ok = !code_i[SEL_W-1];

    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        localparam logic [SEL_W-1:0]  SE_ID   = SEL_W'(i);
        localparam logic [PAIR_W-1:0] PAIR_ID = PAIR_W'(i / 2);
        logic se_hit;
        logic df_hit;

        // Match this switch against the code for each variant.
        always_comb begin
            se_hit = (code_i == SE_ID);
            df_hit = pair_range_ok && (code_i[PAIR_W-1:0] == PAIR_ID);
        end

        assign sw_en_o[i] = en_i && (diff_i ? df_hit : se_hit);
    end

endmodule

// File: rtl/bbm_chsel_seq.sv
// Top: break-before-make channel select sequencer. On an update strobe it
// captures the control word, opens every switch, runs the break timer and,
// when the interval ends, applies the decoded enables from the last word
// captured. Assumes the upstream interface strobes upd_i once per committed
// control word; the switch enables are registered so they are glitch-free.
module bbm_chsel_seq #(
    parameter int unsigned N_SW         = 8,
    parameter int unsigned BREAK_CYCLES = 21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_i,
    input  logic [$clog2(N_SW):0]         ctrl_i,
    input  logic                          diff_i,
    output logic [N_SW-1:0]               sw_en_o,
    output logic                          busy_o
);

    localparam int unsigned SEL_W  = $clog2(N_SW);
    localparam int unsigned CTRL_W = SEL_W + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic              diff_q;
    logic              timer_done;
    logic              timer_running;
    logic [N_SW-1:0]   next_en;
    logic [N_SW-1:0]   sw_en_q;

    // Hold the most recently strobed control word and variant.
    bbm_ctrl_capture #(
        .CTRL_W (CTRL_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (upd_i),
        .ctrl_i (ctrl_i),
        .diff_i (diff_i),
        .ctrl_q (ctrl_q),
        .diff_q (diff_q)
    );

    // Time the all-off interval, restarting on each update.
    bbm_break_timer #(
        .BREAK_CYCLES (BREAK_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (upd_i),
        .running_o (timer_running),
        .done_o    (timer_done)
    );

    // Decode the captured word into the enables applied after the break.
    bbm_chan_decode #(
        .N_SW (N_SW)
    ) u_decode (
        .en_i    (ctrl_q[CTRL_W-1]),
        .code_i  (ctrl_q[SEL_W-1:0]),
        .diff_i  (diff_q),
        .sw_en_o (next_en)
    );

    // Open all switches on update; close the new ones when the break ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en_q <= '0;
        end else if (upd_i) begin
            sw_en_q <= '0;
        end else if (timer_done) begin
            sw_en_q <= next_en;
        end
    end

    assign sw_en_o = sw_en_q;
    assign busy_o  = timer_running;

endmodule

// File: rtl/bbm_chsel_seq_chk.sv
// Checker for the channel sequencer: observes ports only and tracks the
// length of each all-off gap with its own counter. Attached by bind below.
module bbm_chsel_seq_chk #(
    parameter int unsigned N_SW         = 8,
    parameter int unsigned BREAK_CYCLES = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            upd_i,
    input logic [N_SW-1:0] sw_en_o,
    input logic            busy_o
);

    localparam int unsigned GAP_W = $clog2(BREAK_CYCLES + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(BREAK_CYCLES);

    logic [GAP_W-1:0] gap_q;

    // Count cycles of all-off since the last update, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || upd_i) begin
            gap_q <= '0;
        end else if (sw_en_o == '0 && gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1: reset leaves everything off and idle.
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (sw_en_o == '0 && !busy_o));

    // R2: an update opens every switch on the next cycle.
    p_update_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (sw_en_o == '0 && busy_o));

    // R3: no switch is closed while busy.
    p_off_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (sw_en_o == '0));

    // R8: a switch closes only after a full gap since the last update.
    p_min_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|sw_en_o) && !$past(upd_i)) |-> (gap_q >= GAP_MAX));

    // R5: at most one channel or one pair is ever closed.
    p_at_most_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_en_o) <= 2);

    // R6: two closed switches are always the two halves of one pair.
    for (genvar k = 0; k < N_SW / 2; k++) begin : g_pair
        p_pair_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(sw_en_o) == 2) |-> (sw_en_o[2*k] == sw_en_o[2*k+1]));
    end

endmodule

bind bbm_chsel_seq bbm_chsel_seq_chk #(
    .N_SW         (N_SW),
    .BREAK_CYCLES (BREAK_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd_i),
    .sw_en_o (sw_en_o),
    .busy_o  (busy_o)
);

// File: tb/tb_bbm_chsel_seq.sv
// Bench for the channel sequencer: vector table walked by one loop, then
// directed tests for reset, restart during a break and ignored inputs.
module tb_bbm_chsel_seq;

    localparam int unsigned BRK = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_i = 1'b0;
    logic [3:0] ctrl_i = '0;
    logic       diff_i = 1'b0;
    logic [7:0] sw_en_o;
    logic       busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bbm_chsel_seq #(.N_SW(8), .BREAK_CYCLES(BRK)) dut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .ctrl_i(ctrl_i),
        .diff_i(diff_i), .sw_en_o(sw_en_o), .busy_o(busy_o)
    );

    // Vectors: {diff, ctrl[3:0], expected enables[7:0]}.
    localparam int NV = 11;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 4'h8, 8'h01},  // R5 ch0
        {1'b0, 4'hF, 8'h80},  // R5 ch7
        {1'b0, 4'hD, 8'h20},  // R5 ch5
        {1'b0, 4'h7, 8'h00},  // R4 disabled
        {1'b0, 4'hA, 8'h04},  // R5 ch2
        {1'b1, 4'h8, 8'h03},  // R6 pair0
        {1'b1, 4'hB, 8'hC0},  // R6 pair3
        {1'b1, 4'h9, 8'h0C},  // R6 pair1
        {1'b1, 4'hC, 8'h00},  // R7 out of range
        {1'b1, 4'h3, 8'h00},  // R4 disabled
        {1'b1, 4'hA, 8'h30}   // R6 pair2
    };

    task automatic chk(input bit ok, input string req, input logic [8:0] act,
                       input logic [8:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe one update at the next edge; return at the negedge after it.
    task automatic strobe(input logic d, input logic [3:0] c);
        @(negedge clk);
        upd_i = 1'b1; ctrl_i = c; diff_i = d;
        @(negedge clk);
        upd_i = 1'b0;
    endtask

    // Check the break window after a strobe, then the final enables.
    task automatic check_seq(input logic [7:0] exp, input string req);
        bit all_off = 1;
        chk(sw_en_o == 8'h00 && busy_o, "R2", {busy_o, sw_en_o}, {1'b1, 8'h00});
        for (int k = 1; k < BRK; k++) begin
            @(negedge clk);
            if (sw_en_o != 8'h00 || !busy_o) all_off = 0;
        end
        chk(all_off, "R3 window", {busy_o, sw_en_o}, {1'b1, 8'h00});
        @(negedge clk);
        chk(sw_en_o == exp && !busy_o, req, {busy_o, sw_en_o}, {1'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sw_en_o == 8'h00 && !busy_o, "R1 reset", {busy_o, sw_en_o}, 9'h000);
        rst_n = 1'b1;

        // Table walk: each vector goes through a full break sequence.
        for (int v = 0; v < NV; v++) begin
            strobe(VEC[v][12], VEC[v][11:8]);
            check_seq(VEC[v][7:0], "R4/R5/R6/R7 vector");
        end

        // R8: restart three cycles into a break with a new word.
        strobe(1'b0, 4'hF);
        repeat (3) @(negedge clk);
        strobe(1'b0, 4'hA);
        check_seq(8'h04, "R8 restart");

        // R9: inputs wiggle while idle with upd low; outputs must hold.
        begin
            bit held = 1;
            for (int k = 0; k < 6; k++) begin
                ctrl_i = 4'(k * 3 + 8); diff_i = k[0];
                @(negedge clk);
                if (sw_en_o != 8'h04 || busy_o) held = 0;
            end
            chk(held, "R9 idle inputs", {busy_o, sw_en_o}, {1'b0, 8'h04});
        end

        // R9: word changes right after the strobe edge are not captured.
        @(negedge clk);
        upd_i = 1'b1; ctrl_i = 4'h9; diff_i = 1'b1;
        @(negedge clk);
        upd_i = 1'b0; ctrl_i = 4'hF; diff_i = 1'b0;
        check_seq(8'h0C, "R9 captured word");

        // R1: reset in the middle of a break.
        strobe(1'b0, 4'hE);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sw_en_o == 8'h00 && !busy_o, "R1 reset mid-break",
            {busy_o, sw_en_o}, 9'h000);
        rst_n = 1'b1;
        repeat (BRK + 2) @(negedge clk);
        chk(sw_en_o == 8'h00 && !busy_o, "R1 stays off", {busy_o, sw_en_o}, 9'h000);

        // R1: reset while a channel is closed.
        strobe(1'b0, 4'hB);
        check_seq(8'h08, "R5 ch3");
        rst_n = 1'b0;
        @(negedge clk);
        chk(sw_en_o == 8'h00 && !busy_o, "R1 reset closed", {busy_o, sw_en_o}, 9'h000);
        rst_n = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule